// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This block runs single-bit operations on a 32-bit word and registers the result. A request is one cycle with the valid strobe high. The request carries a 3-bit operation code, the source word and a bit selector. The test family reads one bit of the word into a carry output. Depending on the code, it then leaves the word as it is, forces the bit to one, forces it to zero or inverts it, and the modified word appears on the result output. The scan family looks for the first one bit in the word, starting either from the low end or from the high end. It reports the position found and a flag that tells whether the word held any one bit at all.

All outputs are registered. A request sampled at a rising edge is visible on the outputs right after that edge. An output that the operation does not define keeps its earlier value. This means a scan never changes the result word or the carry, and a test never changes the index or the flag. A scan of an all-zero word clears the flag and leaves the index as it was.

Top module: `bitunit`

## Requirements
- R1: For the test codes (0 keep, 1 set, 2 clear, 3 invert), `cf_o` takes the value the selected bit had in `src_i` before any change.
- R2: Code 0 places `src_i` unchanged on `res_o`.
- R3: Codes 1, 2 and 3 place on `res_o` the source word with only the selected bit forced to 1, forced to 0 or inverted. Every other bit equals the source.
- R4: Code 4 (forward scan) places on `idx_o` the position of the lowest one bit of a nonzero source.
- R5: Code 5 (reverse scan) places on `idx_o` the position of the highest one bit of a nonzero source.
- R6: A scan sets `nz_o` to 1 for a nonzero source. For an all-zero source it sets `nz_o` to 0 and leaves `idx_o` at its earlier value.
- R7: Only the low 5 bits of `sel_i` pick the bit, so the selector is taken modulo 32.
- R8: Results appear in the cycle after the request. Outputs that the operation does not define keep their value, and every output holds while `in_valid` is low.
- R9: Codes 6 and 7 are reserved and change no output.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| src_i | input | 32 | Source word |
| sel_i | input | 8 | Bit selector (low 5 bits used) |
| res_o | output | 32 | Modified word from the test codes |
| idx_o | output | 5 | Index from the scan codes |
| cf_o | output | 1 | Tested bit value |
| nz_o | output | 1 | Scan source was nonzero |

## Verification
Each request is followed at once by a compare, so a wrong mask, a wrong priority order or a wrong hold enable shows on the ports one cycle after the request that triggers it. A stale register only shows when a later operation should have left it untouched. For that reason, idle cycles, reserved codes and zero-source scans are mixed in between the other operations, so that a lost hold shows in the very next comparison.

// File: rtl/bitunit_pkg.sv
package bitunit_pkg;
  typedef enum logic [2:0] {
    BOP_TEST  = 3'd0,
    BOP_SET   = 3'd1,
    BOP_CLR   = 3'd2,
    BOP_FLIP  = 3'd3,
    BOP_SCANF = 3'd4,
    BOP_SCANR = 3'd5
  } bop_e;
endpackage

// File: rtl/bit_modify.sv
module bit_modify
  import bitunit_pkg::*;
#(
  parameter int W    = 32,
  localparam int IDXW = $clog2(W)
) (
  input  logic [2:0]      op,
  input  logic [W-1:0]    src,
  input  logic [IDXW-1:0] pos,
  output logic [W-1:0]    word,
  output logic            tbit
);
  logic [W-1:0] mask;

  always_comb begin
    mask = '0;
    mask[pos] = 1'b1;
    tbit = src[pos];
    case (op)
      BOP_SET:  word = src | mask;
      BOP_CLR:  word = src & ~mask;
      BOP_FLIP: word = src ^ mask;
      default:  word = src;
    endcase
  end
endmodule

// File: rtl/bit_scan.sv
module bit_scan #(
  parameter int W       = 32,
  parameter bit REVERSE = 1'b0,
  localparam int IDXW   = $clog2(W)
) (
  input  logic [W-1:0]    src,
  output logic [IDXW-1:0] idx,
  output logic            found
);
  // The last match in loop order wins, so walk away from the preferred end.
  generate
    if (REVERSE) begin : g_high_first
      always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++)
          if (src[i]) idx = IDXW'(i);
      end
    end else begin : g_low_first
      always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--)
          if (src[i]) idx = IDXW'(i);
      end
    end
  endgenerate

  assign found = |src;
endmodule

// File: rtl/bitunit.sv
module bitunit
  import bitunit_pkg::*;
#(
  parameter int W     = 32,
  parameter int SEL_W = 8,
  localparam int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op_i,
  input  logic [W-1:0]    src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]    res_o,
  output logic [IDXW-1:0] idx_o,
  output logic            cf_o,
  output logic            nz_o
);
  logic [IDXW-1:0] pos;
  logic [W-1:0]    mod_word;
  logic            mod_bit;
  logic [IDXW-1:0] fwd_idx, rev_idx;
  logic            fwd_any, rev_any;

  logic            is_test, is_fwd, is_rev;
  logic            en_res, en_cf, en_idx, en_nz;
  logic [W-1:0]    res_d;
  logic [IDXW-1:0] idx_d;
  logic            cf_d, nz_d;

  assign pos = sel_i[IDXW-1:0];

  bit_modify #(.W(W)) u_mod (
    .op(op_i), .src(src_i), .pos(pos), .word(mod_word), .tbit(mod_bit)
  );

  bit_scan #(.W(W), .REVERSE(1'b0)) u_fwd (
    .src(src_i), .idx(fwd_idx), .found(fwd_any)
  );

  bit_scan #(.W(W), .REVERSE(1'b1)) u_rev (
    .src(src_i), .idx(rev_idx), .found(rev_any)
  );

  always_comb begin
    is_test = in_valid && (op_i <= BOP_FLIP);
    is_fwd  = in_valid && (op_i == BOP_SCANF);
    is_rev  = in_valid && (op_i == BOP_SCANR);

    en_res = is_test;
    en_cf  = is_test;
    en_nz  = is_fwd || is_rev;
    en_idx = (is_fwd && fwd_any) || (is_rev && rev_any);

    res_d = mod_word;
    cf_d  = mod_bit;
    nz_d  = is_fwd ? fwd_any : rev_any;
    idx_d = is_fwd ? fwd_idx : rev_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      cf_o  <= 1'b0;
      idx_o <= '0;
      nz_o  <= 1'b0;
    end else begin
      if (en_res) res_o <= res_d;
      if (en_cf)  cf_o  <= cf_d;
      if (en_idx) idx_o <= idx_d;
      if (en_nz)  nz_o  <= nz_d;
    end
  end
endmodule

// File: rtl/bitunit_chk.sv
module bitunit_chk
  import bitunit_pkg::*;
#(
  parameter int W     = 32,
  parameter int SEL_W = 8,
  localparam int IDXW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      op_i,
  input logic [W-1:0]    src_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [W-1:0]    res_o,
  input logic [IDXW-1:0] idx_o,
  input logic            cf_o,
  input logic            nz_o
);
  a_r1_carry_is_old_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i <= 3'd3) |=> cf_o == $past(src_i[sel_i[IDXW-1:0]]));

  a_r2_test_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 3'd0) |=> res_o == $past(src_i));

  a_r3_one_bit_touched: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i >= 3'd1 && op_i <= 3'd3) |=> $countones(res_o ^ $past(src_i)) <= 1);

  a_r5_scan_hits_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_i == 3'd4 || op_i == 3'd5) && src_i != '0)
      |=> nz_o && (($past(src_i) >> idx_o) & 1) == 1);

  a_r6_zero_scan_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_i == 3'd4 || op_i == 3'd5) && src_i == '0)
      |=> !nz_o && $stable(idx_o));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_o) && $stable(idx_o) && $stable(cf_o) && $stable(nz_o));

  a_r9_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i >= 3'd6) |=> $stable(res_o) && $stable(idx_o) && $stable(cf_o) && $stable(nz_o));
endmodule

bind bitunit bitunit_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .src_i(src_i),
  .sel_i(sel_i), .res_o(res_o), .idx_o(idx_o), .cf_o(cf_o), .nz_o(nz_o)
);

// File: tb/bitunit_test.sv
`timescale 1ns/1ps
module bitunit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_i;
  logic [31:0] src_i;
  logic [7:0]  sel_i;
  logic [31:0] res_o;
  logic [4:0]  idx_o;
  logic        cf_o, nz_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_res;
  logic [4:0]  m_idx;
  logic        m_cf, m_nz;

  always #2.5 clk = ~clk;

  bitunit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .src_i(src_i),
    .sel_i(sel_i), .res_o(res_o), .idx_o(idx_o), .cf_o(cf_o), .nz_o(nz_o)
  );

  function automatic logic [4:0] low_one(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [4:0] high_one(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tres, input string tcf, input string tidx, input string tnz);
    check(tres, res_o, m_res);
    check(tcf, {31'd0, cf_o}, {31'd0, m_cf});
    check(tidx, {27'd0, idx_o}, {27'd0, m_idx});
    check(tnz, {31'd0, nz_o}, {31'd0, m_nz});
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] src, input logic [7:0] sel);
    logic [4:0] p;
    string tr, tc, ti, tn;
    @(negedge clk);
    in_valid = 1'b1; op_i = op; src_i = src; sel_i = sel;
    p = sel[4:0];
    tr = "R8"; tc = "R8"; ti = "R8"; tn = "R8";
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        m_cf = src[p]; tc = "R1";
        m_res = src;
        if (op == 3'd1) m_res[p] = 1'b1;
        if (op == 3'd2) m_res[p] = 1'b0;
        if (op == 3'd3) m_res[p] = ~src[p];
        tr = (op == 3'd0) ? "R2" : "R3";
        if (sel[7:5] != 3'd0) begin tr = "R7"; tc = "R7"; end
      end
      3'd4, 3'd5: begin
        tn = "R6";
        if (src != 32'd0) begin
          m_idx = (op == 3'd4) ? low_one(src) : high_one(src);
          m_nz = 1'b1;
          ti = (op == 3'd4) ? "R4" : "R5";
        end else begin
          m_nz = 1'b0; ti = "R6";
        end
      end
      default: begin tr = "R9"; tc = "R9"; ti = "R9"; tn = "R9"; end
    endcase
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_all(tr, tc, ti, tn);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    src_i = $urandom; op_i = 3'($urandom); sel_i = 8'($urandom);
    @(posedge clk); #1;
    check_all("R8", "R8", "R8", "R8");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; in_valid = 1'b0; op_i = '0; src_i = '0; sel_i = '0;
    m_res = '0; m_idx = '0; m_cf = 1'b0; m_nz = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R10", "R10", "R10", "R10");
    @(negedge clk); rst_n = 1'b1;

    issue(3'd4, 32'h8000_0001, 8'd0);
    issue(3'd5, 32'h8000_0001, 8'd0);
    issue(3'd4, 32'h0000_0000, 8'd0);
    issue(3'd5, 32'h0001_0000, 8'd0);
    issue(3'd5, 32'h0000_0000, 8'd0);
    issue(3'd0, 32'hA5A5_0F0F, 8'hE3);
    issue(3'd1, 32'h0000_0000, 8'd31);
    issue(3'd2, 32'hFFFF_FFFF, 8'd0);
    issue(3'd3, 32'h1234_5678, 8'h47);
    issue(3'd6, 32'hFFFF_FFFF, 8'd5);
    issue(3'd7, 32'h0000_0000, 8'd9);
    idle_check();
    issue(3'd4, 32'h8000_0000, 8'd0);
    issue(3'd5, 32'h0000_0001, 8'd0);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] v;
      v = $urandom;
      case ($urandom % 4)
        0: v = 32'd0;
        1: v = 32'd1 << ($urandom % 32);
        default: ;
      endcase
      if ($urandom % 6 == 0) idle_check();
      else issue(3'($urandom % 8), v, 8'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule